// File: doc/BRIEF.md
# Interrupt Request Router

The block gathers sixteen peripheral request lines and steers them onto four processor interrupt pins. Three pins are plain level interrupts. The fourth is a vectored interrupt that carries the handler address of the line that was picked and a flag asking the core to switch context. Software programs and services the block through a 16-bit register window.

Each line is first conditioned by its own polarity bit. It is then captured in one of two ways. In edge-latched (sticky) mode an event stays held until software acknowledges it. In level mode the pending bit follows the input. Software can also raise any line itself, and that request always stays held until it is acknowledged. Each output pin has its own line mask, and each pin is registered as the OR of the pending lines its mask lets through. Software reads the pending word, finds the line, handles it, and then writes a one to that line's acknowledge bit.

The block has no streaming data path, so every pin is a plain control or status signal with no valid/ready handshake. A register write takes effect on the clock edge at which `bus_wr` is high. Reads are combinational from `bus_addr` and need no strobe.

Top module: `irq_router_top`

## Requirements
- R1: After reset every register holds 0, the pending word at offset 0x200 reads 0, and `core_int`, `core_vint`, `vint_addr` and `vint_ctx` are all 0.
- R2: The polarity register is at offset 0x210. Bit N set inverts input N before capture, so a low input counts as asserted.
- R3: The mode register is at offset 0x20E, and bit N = 1 puts line N in sticky mode. In sticky mode, a rising edge of the conditioned input sets pending bit N one clock later. The bit then stays set after the input falls, until it is acknowledged.
- R4: With mode bit N = 0, pending bit N equals the conditioned input in the same cycle. An acknowledge does not clear it while that level is held.
- R5: The acknowledge register is at offset 0x202. Writing 1 to bit N clears the held pending state of line N, writing 0 leaves it unchanged, and the register reads 0.
- R6: Writing 1 to bit N of the trigger register at offset 0x204 sets pending bit N on that write edge, in either mode. The bit stays set until it is acknowledged, and the trigger register reads 0.
- R7: If a sticky rising edge and an acknowledge reach the same line in the same cycle, the pending bit ends up set.
- R8: The masks for `core_int[0]`, `core_int[1]` and `core_int[2]` are at offsets 0x206, 0x208 and 0x20A. Each `core_int[k]` is high one clock after any pending line whose mask bit is set, and low one clock after no such line remains.
- R9: The vectored mask is at offset 0x20C. One clock after any masked line is pending, `core_vint` is 1 and `vint_addr` holds the 18-bit handler address of the lowest-numbered such line. When no masked line is pending, `vint_addr` is 0.
- R10: `vint_ctx` is 1 exactly when `core_vint` is 1 and the selected line's context-switch bit is set.
- R11: The word at offset 0x212+4N holds line N's context-switch bit in bit 15 and handler-address bits 17:16 in bits 1:0; its other bits read 0. The word at 0x214+4N holds address bits 15:0.
- R12: The four masks, the mode register and the polarity register read back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 16 | Raw peripheral request lines |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| core_int | output | 3 | Plain processor interrupts |
| core_vint | output | 1 | Vectored processor interrupt |
| vint_addr | output | 18 | Handler address of the selected vectored line |
| vint_ctx | output | 1 | Context-switch request for the selected line |

## Verification
A hardware event and a software acknowledge can reach the same line's held flag on the same edge. The bench provokes this by raising a sticky line's input in the same cycle that an acknowledge write for that line is driven. It passes if the pending word still shows the line afterwards, and a second acknowledge, given with no new edge, then clears it. The bench also steps the vectored output through two pending lines. It checks that acknowledging the winning line hands `vint_addr` and `vint_ctx` to the next line one clock later.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int WORD_W    = 16;
  localparam int NUM_LINES = 16;
  localparam int NUM_PLAIN = 3;
  localparam int HADDR_W   = 18;
  localparam int HI_W      = HADDR_W - WORD_W;
  localparam int ADDR_W    = 12;

  localparam int BASE_ADDR = 'h200;
  localparam int IDX_PEND  = 0;
  localparam int IDX_ACK   = 1;
  localparam int IDX_TRIG  = 2;
  localparam int IDX_MASK0 = 3;
  localparam int IDX_VMASK = IDX_MASK0 + NUM_PLAIN;
  localparam int IDX_MODE  = IDX_VMASK + 1;
  localparam int IDX_POL   = IDX_MODE + 1;
  localparam int NUM_CTL   = IDX_POL + 1;
  localparam int VEC_BASE  = BASE_ADDR + 2 * NUM_CTL;

  typedef struct packed {
    logic            ctx;
    logic [HI_W-1:0] hi;
    logic [WORD_W-1:0] lo;
  } vec_ent_t;
endpackage

// File: rtl/irq_line.sv
module irq_line (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic invert,
  input  logic sticky,
  input  logic sw_set,
  input  logic ack,
  output logic pending
);
  logic cond, cond_q, rise, hold_q, set_now;

  assign cond    = raw ^ invert;
  assign rise    = cond & ~cond_q;
  assign set_now = sw_set | (sticky & rise);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cond_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      cond_q <= cond;
      if (set_now)  hold_q <= 1'b1;
      else if (ack) hold_q <= 1'b0;
    end
  end

  assign pending = hold_q | (~sticky & cond);

  assert_set_beats_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && (sw_set || (sticky && cond && !cond_q))) |=> pending)
    else $error("set lost against acknowledge");

  assert_sticky_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky && hold_q && !ack && $stable(sticky)) |=> pending)
    else $error("held flag dropped without acknowledge");
endmodule

// File: rtl/irq_reg_bank.sv
module irq_reg_bank
  import irq_router_pkg::*;
#(
  parameter int N_LINES = NUM_LINES,
  parameter int AW      = ADDR_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [AW-1:0]                  bus_addr,
  input  logic                           bus_wr,
  input  logic [WORD_W-1:0]              bus_wdata,
  output logic [WORD_W-1:0]              bus_rdata,
  input  logic [N_LINES-1:0]             pend_i,
  output logic [N_LINES-1:0]             ack_o,
  output logic [N_LINES-1:0]             trig_o,
  output logic [NUM_PLAIN-1:0][N_LINES-1:0] plain_mask_o,
  output logic [N_LINES-1:0]             vec_mask_o,
  output logic [N_LINES-1:0]             mode_o,
  output logic [N_LINES-1:0]             pol_o,
  output vec_ent_t [N_LINES-1:0]         vec_tab_o
);
  logic [NUM_CTL-1:0] ctl_hit;
  logic [N_LINES-1:0] vhi_hit, vlo_hit;

  for (genvar k = 0; k < NUM_CTL; k++) begin : g_ctl
    localparam logic [AW-1:0] A = AW'(BASE_ADDR + 2 * k);
    assign ctl_hit[k] = (bus_addr == A);
  end

  for (genvar n = 0; n < N_LINES; n++) begin : g_vdec
    localparam logic [AW-1:0] AH = AW'(VEC_BASE + 4 * n);
    localparam logic [AW-1:0] AL = AW'(VEC_BASE + 4 * n + 2);
    assign vhi_hit[n] = (bus_addr == AH);
    assign vlo_hit[n] = (bus_addr == AL);
  end

  logic [NUM_PLAIN-1:0][N_LINES-1:0] plain_mask_q;
  logic [N_LINES-1:0] vec_mask_q, mode_q, pol_q;
  vec_ent_t [N_LINES-1:0] vec_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      plain_mask_q <= '0;
      vec_mask_q   <= '0;
      mode_q       <= '0;
      pol_q        <= '0;
      vec_q        <= '0;
    end else if (bus_wr) begin
      for (int k = 0; k < NUM_PLAIN; k++)
        if (ctl_hit[IDX_MASK0 + k]) plain_mask_q[k] <= N_LINES'(bus_wdata);
      if (ctl_hit[IDX_VMASK]) vec_mask_q <= N_LINES'(bus_wdata);
      if (ctl_hit[IDX_MODE])  mode_q     <= N_LINES'(bus_wdata);
      if (ctl_hit[IDX_POL])   pol_q      <= N_LINES'(bus_wdata);
      for (int n = 0; n < N_LINES; n++) begin
        if (vhi_hit[n]) begin
          vec_q[n].ctx <= bus_wdata[WORD_W-1];
          vec_q[n].hi  <= bus_wdata[HI_W-1:0];
        end
        if (vlo_hit[n]) vec_q[n].lo <= bus_wdata;
      end
    end
  end

  function automatic logic [WORD_W-1:0] hi_word(vec_ent_t e);
    hi_word = '0;
    hi_word[WORD_W-1] = e.ctx;
    hi_word[HI_W-1:0] = e.hi;
  endfunction

  always_comb begin
    bus_rdata = '0;
    if (ctl_hit[IDX_PEND])  bus_rdata = WORD_W'(pend_i);
    for (int k = 0; k < NUM_PLAIN; k++)
      if (ctl_hit[IDX_MASK0 + k]) bus_rdata = WORD_W'(plain_mask_q[k]);
    if (ctl_hit[IDX_VMASK]) bus_rdata = WORD_W'(vec_mask_q);
    if (ctl_hit[IDX_MODE])  bus_rdata = WORD_W'(mode_q);
    if (ctl_hit[IDX_POL])   bus_rdata = WORD_W'(pol_q);
    for (int n = 0; n < N_LINES; n++) begin
      if (vhi_hit[n]) bus_rdata = hi_word(vec_q[n]);
      if (vlo_hit[n]) bus_rdata = vec_q[n].lo;
    end
  end

  assign ack_o        = (bus_wr && ctl_hit[IDX_ACK])  ? N_LINES'(bus_wdata) : '0;
  assign trig_o       = (bus_wr && ctl_hit[IDX_TRIG]) ? N_LINES'(bus_wdata) : '0;
  assign plain_mask_o = plain_mask_q;
  assign vec_mask_o   = vec_mask_q;
  assign mode_o       = mode_q;
  assign pol_o        = pol_q;
  assign vec_tab_o    = vec_q;

  assert_strobes_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |-> (ack_o == '0 && trig_o == '0))
    else $error("strobe without write");

  assert_mode_kept_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(mode_o) && $stable(pol_o) && $stable(vec_mask_o))
    else $error("configuration changed without write");
endmodule

// File: rtl/irq_vec_pick.sv
module irq_vec_pick #(
  parameter int N_LINES = 16,
  localparam int IDX_W  = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] req,
  output logic               valid,
  output logic [IDX_W-1:0]   idx
);
  logic [N_LINES-1:0] grant;

  always_comb begin
    idx = '0;
    for (int n = N_LINES - 1; n >= 0; n--)
      if (req[n]) idx = IDX_W'(n);
  end

  assign valid = |req;
  assign grant = valid ? (N_LINES'(1) << idx) : '0;

  assert_grant_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & req) == grant))
    else $error("grant not a single requesting line");

  assert_grant_lowest_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ((req & (grant - N_LINES'(1))) == '0))
    else $error("a lower line was passed over");
endmodule

// File: rtl/irq_router_top.sv
module irq_router_top
  import irq_router_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [WORD_W-1:0]    bus_wdata,
  output logic [WORD_W-1:0]    bus_rdata,
  output logic [NUM_PLAIN-1:0] core_int,
  output logic                 core_vint,
  output logic [HADDR_W-1:0]   vint_addr,
  output logic                 vint_ctx
);
  localparam int IDX_W = $clog2(NUM_LINES);

  logic [NUM_LINES-1:0] pend, ack, trig, vmask, mode, pol;
  logic [NUM_PLAIN-1:0][NUM_LINES-1:0] pmask;
  vec_ent_t [NUM_LINES-1:0] vtab;
  logic vsel_valid;
  logic [IDX_W-1:0] vsel_idx;

  irq_reg_bank #(.N_LINES(NUM_LINES), .AW(ADDR_W)) u_regs (
    .clk, .rst_n, .bus_addr, .bus_wr, .bus_wdata, .bus_rdata,
    .pend_i(pend), .ack_o(ack), .trig_o(trig), .plain_mask_o(pmask),
    .vec_mask_o(vmask), .mode_o(mode), .pol_o(pol), .vec_tab_o(vtab)
  );

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    irq_line u_line (
      .clk, .rst_n, .raw(irq_in[n]), .invert(pol[n]), .sticky(mode[n]),
      .sw_set(trig[n]), .ack(ack[n]), .pending(pend[n])
    );
  end

  irq_vec_pick #(.N_LINES(NUM_LINES)) u_pick (
    .clk, .rst_n, .req(pend & vmask), .valid(vsel_valid), .idx(vsel_idx)
  );

  for (genvar k = 0; k < NUM_PLAIN; k++) begin : g_plain
    always_ff @(posedge clk) begin
      if (!rst_n) core_int[k] <= 1'b0;
      else        core_int[k] <= |(pend & pmask[k]);
    end

    assert_route_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|(pend & pmask[k])) |=> core_int[k])
      else $error("routed request did not reach plain output");
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      core_vint <= 1'b0;
      vint_addr <= '0;
      vint_ctx  <= 1'b0;
    end else begin
      core_vint <= vsel_valid;
      vint_addr <= vsel_valid ? {vtab[vsel_idx].hi, vtab[vsel_idx].lo} : '0;
      vint_ctx  <= vsel_valid & vtab[vsel_idx].ctx;
    end
  end

  assert_vint_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !core_vint |-> (vint_addr == '0 && !vint_ctx))
    else $error("vector fields live while idle");

  assert_ctx_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    vint_ctx |-> core_vint)
    else $error("context switch without vectored interrupt");
endmodule

// File: tb/test_irq_router_top.sv
`timescale 1ns/1ps
module test_irq_router_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_in = '0;
  logic [11:0] bus_addr = 12'h200;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [2:0]  core_int;
  logic        core_vint;
  logic [17:0] vint_addr;
  logic        vint_ctx;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_router_top i_irq_router_top (
    .clk, .rst_n, .irq_in, .bus_addr, .bus_wr, .bus_wdata, .bus_rdata,
    .core_int, .core_vint, .vint_addr, .vint_ctx
  );

  typedef struct {
    int          sel;
    logic [31:0] val;
    string       tag;
  } exp_t;
  exp_t sb[$];

  function automatic logic [31:0] observe(int sel);
    case (sel)
      0: return {16'h0, bus_rdata};
      1: return {29'h0, core_int};
      2: return {31'h0, core_vint};
      3: return {14'h0, vint_addr};
      default: return {31'h0, vint_ctx};
    endcase
  endfunction

  // monitor: compares queued expectations just after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
        exp_t e;
        logic [31:0] got;
        e = sb.pop_front();
        got = observe(e.sel);
        checks++;
        if (got !== e.val) begin
          failures++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", e.tag, e.sel, got, e.val);
        end
      end
    end
  end

  task automatic expect_v(int sel, logic [31:0] v, string tag);
    exp_t e;
    e.sel = sel; e.val = v; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(logic [11:0] a, logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, logic [15:0] v, string tag);
    bus_addr = a;
    expect_v(0, {16'h0, v}, tag);
    step();
  endtask

  task automatic vec_out(logic v, logic [17:0] a, logic c, string tag);
    expect_v(2, {31'h0, v}, tag);
    expect_v(3, {14'h0, a}, tag);
    expect_v(4, {31'h0, c}, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    // R1 reset state
    expect_v(1, 0, "R1");
    vec_out(1'b0, 18'h0, 1'b0, "R1");
    rd(12'h200, 16'h0000, "R1");

    wr(12'h206, 16'h0003);
    wr(12'h208, 16'h0020);
    wr(12'h20A, 16'h8000);
    wr(12'h20C, 16'h0C00);
    wr(12'h20E, 16'h0C03);
    wr(12'h210, 16'h0002);
    // R2 inverted idle-low line 1 appears as a rising edge
    step();
    rd(12'h200, 16'h0002, "R2");
    expect_v(1, 1, "R8");
    rd(12'h206, 16'h0003, "R12");
    rd(12'h20E, 16'h0C03, "R12");
    rd(12'h210, 16'h0002, "R12");
    rd(12'h20C, 16'h0C00, "R12");

    // R5 write zero ignored, write one clears, reads zero
    wr(12'h202, 16'h0000);
    rd(12'h200, 16'h0002, "R5");
    wr(12'h202, 16'h0002);
    rd(12'h200, 16'h0000, "R5");
    rd(12'h202, 16'h0000, "R5");
    expect_v(1, 0, "R8");

    // R2 pulse low then high again on inverted line
    irq_in[1] = 1'b1; step(); step();
    irq_in[1] = 1'b0; step();
    rd(12'h200, 16'h0002, "R2");
    wr(12'h202, 16'h0002);

    // R3 sticky capture outlives the input
    irq_in[0] = 1'b1; step();
    irq_in[0] = 1'b0;
    rd(12'h200, 16'h0001, "R3");
    expect_v(1, 1, "R8");
    step();
    rd(12'h200, 16'h0001, "R3");
    wr(12'h202, 16'h0001);
    rd(12'h200, 16'h0000, "R3");

    // R4 level mode follows input, ack has no effect
    irq_in[5] = 1'b1;
    rd(12'h200, 16'h0020, "R4");
    expect_v(1, 2, "R8");
    wr(12'h202, 16'h0020);
    rd(12'h200, 16'h0020, "R4");
    irq_in[5] = 1'b0;
    rd(12'h200, 16'h0000, "R4");
    expect_v(1, 0, "R8");

    // R6 software trigger on a level-mode line
    wr(12'h204, 16'h0020);
    rd(12'h200, 16'h0020, "R6");
    rd(12'h204, 16'h0000, "R6");
    wr(12'h202, 16'h0020);
    rd(12'h200, 16'h0000, "R6");

    // R7 edge and acknowledge on the same edge
    bus_addr = 12'h202; bus_wdata = 16'h0001; bus_wr = 1'b1; irq_in[0] = 1'b1;
    step();
    bus_wr = 1'b0;
    rd(12'h200, 16'h0001, "R7");
    wr(12'h202, 16'h0001);
    rd(12'h200, 16'h0000, "R7");
    irq_in[0] = 1'b0;

    // R8 two outputs at once
    irq_in[15] = 1'b1;
    wr(12'h204, 16'h0001);
    rd(12'h200, 16'h8001, "R8");
    expect_v(1, 5, "R8");
    irq_in[15] = 1'b0;
    wr(12'h202, 16'h0001);
    step();
    expect_v(1, 0, "R8");

    // R9 / R10 vectored selection
    wr(12'h23A, 16'h0002);
    wr(12'h23C, 16'h1234);
    wr(12'h23E, 16'h8001);
    wr(12'h240, 16'hABCD);
    vec_out(1'b0, 18'h0, 1'b0, "R9");
    wr(12'h204, 16'h0C00);
    step();
    vec_out(1'b1, 18'h21234, 1'b0, "R9");
    wr(12'h202, 16'h0400);
    step();
    vec_out(1'b1, 18'h1ABCD, 1'b1, "R10");
    wr(12'h202, 16'h0800);
    step();
    vec_out(1'b0, 18'h0, 1'b0, "R9");

    // R11 vector word layout
    rd(12'h23A, 16'h0002, "R11");
    rd(12'h23E, 16'h8001, "R11");
    rd(12'h240, 16'hABCD, "R11");
    wr(12'h21E, 16'hFFFF);
    rd(12'h21E, 16'h8003, "R11");

    step(); step();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule